// File: doc/BRIEF.md
# Safe-State Operating Mode Controller

This block chooses the operating mode of a safety logic unit and decides, for every output on every cycle, whether the output follows the application logic or is held safe. It has five modes: startup, run, configuration, software upgrade and fatal error. Only run mode lets the application logic reach the outputs. In every other mode, and in the same cycle that an internal fault flag is raised, every output is driven low. No continuous activity is needed to keep outputs low.

In run mode, an output with an external failure reported against it reacts in the way the integrator chose for that output. It is either driven low, or it is put into an OFF-state whose drive level the integrator also supplies. A configuration is accepted only in configuration mode, and that mode can be entered only when a request arrives together with a password match. A deadline monitor counts 1 ms ticks while the unit is outside run mode and the output feedback still shows drive. If the safe state is not reached within the limit (500 ms by default), it raises a sticky error that forces the fatal error mode. The fatal error mode is left only through reset.

Top module: `safe_mode_ctrl`

## Requirements
- R1: After reset the mode is startup (code 0), and drv_out, off_state, cfg_accept and deadline_err are all 0, whatever the other inputs are.
- R2: In startup the mode stays at startup until startup_ok is 1 at a clock edge. The mode then becomes run (code 1).
- R3: In run mode with no fault, an output with ext_fail low drives the value of its logic_out bit.
- R4: In run mode, an output with ext_fail high drives 0 with off_state 0 when its off_sel bit is 0. When its off_sel bit is 1, it drives its off_level bit and its off_state bit is 1.
- R5: In run mode, cfg_req together with pwd_ok moves the mode to configuration (code 2) at the next edge, and this takes priority over upg_req. cfg_req without pwd_ok leaves the mode in run, with cfg_accept 0.
- R6: In configuration mode cfg_accept is 1 and all drv_out and off_state bits are 0. cfg_done returns the mode to startup. cfg_accept is 0 in every other mode.
- R7: upg_req in run mode (without an authorized cfg_req) moves the mode to upgrade (code 3). There all outputs are 0 and cfg_accept is 0, and upg_done returns the mode to startup.
- R8: fault_int forces all drv_out bits to 0 in the same cycle and the mode to fatal (code 4) at the next edge, from any mode. Fatal mode ignores all inputs until reset.
- R9: Outside run mode, if out_fb is nonzero on LIMIT_MS consecutive ticks, deadline_err rises at the edge of the last such tick. The mode becomes fatal one edge later. The error stays set until reset. Fewer ticks, or a return of out_fb to 0, raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| startup_ok | input | 1 | Startup self-tests passed |
| fault_int | input | 1 | Internal dangerous fault detected |
| cfg_req | input | 1 | Request to enter configuration |
| pwd_ok | input | 1 | Password matched for the configuration request |
| cfg_done | input | 1 | Configuration finished |
| upg_req | input | 1 | Request to enter software upgrade |
| upg_done | input | 1 | Software upgrade finished |
| logic_out | input | N_OUT | Output values demanded by the application logic |
| ext_fail | input | N_OUT | External failure detected per output |
| off_sel | input | N_OUT | Per-output reaction: 0 drive low, 1 OFF-state |
| off_level | input | N_OUT | Per-output drive level in OFF-state |
| out_fb | input | N_OUT | Readback of the physical output drive |
| drv_out | output | N_OUT | Gated output drive |
| off_state | output | N_OUT | Outputs currently in OFF-state |
| cfg_accept | output | 1 | Configuration may be written |
| mode | output | 3 | Current mode code |
| deadline_err | output | 1 | Safe state not reached in time (sticky) |

## Verification
Some properties are checked on every cycle by the assertions. Fatal mode and the deadline error never clear. A raised fault always leads to fatal mode. An unauthorized configuration request never reaches configuration mode. Outside run mode the drive is always zero. Only the bench scenarios can show the rest. These are the per-output reaction table, swept exactly over all input combinations in run mode, the ordering and priority of the mode transitions, and the tick count at which the deadline error appears, including the count one short of the limit.

// File: rtl/safe_mode_pkg.sv
package safe_mode_pkg;
  typedef enum logic [2:0] {
    M_STARTUP = 3'd0,
    M_RUN     = 3'd1,
    M_CONFIG  = 3'd2,
    M_UPGRADE = 3'd3,
    M_FATAL   = 3'd4
  } mode_e;
endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
  import safe_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fault_int,
  input  logic  dl_err,
  input  logic  startup_ok,
  input  logic  cfg_req,
  input  logic  pwd_ok,
  input  logic  cfg_done,
  input  logic  upg_req,
  input  logic  upg_done,
  output mode_e mode_q
);
  mode_e mode_d;
  logic  mode_en;

  always_comb begin
    mode_d = mode_q;
    if (fault_int || dl_err) begin
      mode_d = M_FATAL;
    end else begin
      case (mode_q)
        M_STARTUP: if (startup_ok) mode_d = M_RUN;
        M_RUN: begin
          if (cfg_req && pwd_ok) mode_d = M_CONFIG;
          else if (upg_req)      mode_d = M_UPGRADE;
        end
        M_CONFIG:  if (cfg_done) mode_d = M_STARTUP;
        M_UPGRADE: if (upg_done) mode_d = M_STARTUP;
        M_FATAL:   mode_d = M_FATAL;
        default:   mode_d = M_FATAL;
      endcase
    end
  end

  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_STARTUP;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  // R8: fatal mode is never left without reset
  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FATAL) |=> (mode_q == M_FATAL));

  // R8: a raised fault always lands in fatal mode
  assert_fault_to_fatal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_int |=> (mode_q == M_FATAL));

  // R5: no entry into configuration without a password match
  assert_no_unauth_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_CONFIG && !(cfg_req && pwd_ok)) |=> (mode_q != M_CONFIG));
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int N_OUT = 4
) (
  input  logic             run_en,
  input  logic [N_OUT-1:0] logic_out,
  input  logic [N_OUT-1:0] ext_fail,
  input  logic [N_OUT-1:0] off_sel,
  input  logic [N_OUT-1:0] off_level,
  output logic [N_OUT-1:0] drv_out,
  output logic [N_OUT-1:0] off_state
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    logic in_off;
    assign in_off       = run_en && ext_fail[i] && off_sel[i];
    assign off_state[i] = in_off;
    always_comb begin
      if (!run_en)          drv_out[i] = 1'b0;
      else if (!ext_fail[i]) drv_out[i] = logic_out[i];
      else if (in_off)      drv_out[i] = off_level[i];
      else                  drv_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/deadline_mon.sv
module deadline_mon #(
  parameter int N_OUT    = 4,
  parameter int LIMIT_MS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             safe_req,
  input  logic [N_OUT-1:0] out_fb,
  output logic             dl_err
);
  localparam int CW = $clog2(LIMIT_MS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_d;
  logic          pending;
  logic          cnt_en;

  assign pending = safe_req && (|out_fb);
  assign cnt_en  = tick_1ms || !pending;

  always_comb begin
    cnt_d = cnt_q;
    err_d = dl_err;
    if (!pending) begin
      cnt_d = '0;
    end else if (tick_1ms) begin
      if (cnt_q == CW'(LIMIT_MS - 1)) err_d = 1'b1;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_err <= 1'b0;
    end else if (err_d) begin
      dl_err <= 1'b1;
    end
  end

  // R9: the deadline error is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dl_err |=> dl_err);

  // R9: the error never rises without pending feedback and a tick
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dl_err && !(pending && tick_1ms)) |=> !dl_err);
endmodule

// File: rtl/safe_mode_ctrl.sv
module safe_mode_ctrl
  import safe_mode_pkg::*;
#(
  parameter int N_OUT    = 4,
  parameter int LIMIT_MS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             startup_ok,
  input  logic             fault_int,
  input  logic             cfg_req,
  input  logic             pwd_ok,
  input  logic             cfg_done,
  input  logic             upg_req,
  input  logic             upg_done,
  input  logic [N_OUT-1:0] logic_out,
  input  logic [N_OUT-1:0] ext_fail,
  input  logic [N_OUT-1:0] off_sel,
  input  logic [N_OUT-1:0] off_level,
  input  logic [N_OUT-1:0] out_fb,
  output logic [N_OUT-1:0] drv_out,
  output logic [N_OUT-1:0] off_state,
  output logic             cfg_accept,
  output logic [2:0]       mode,
  output logic             deadline_err
);
  mode_e mode_q;
  logic  dl_err;
  logic  run_en;

  mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_int  (fault_int),
    .dl_err     (dl_err),
    .startup_ok (startup_ok),
    .cfg_req    (cfg_req),
    .pwd_ok     (pwd_ok),
    .cfg_done   (cfg_done),
    .upg_req    (upg_req),
    .upg_done   (upg_done),
    .mode_q     (mode_q)
  );

  assign run_en = (mode_q == M_RUN) && !fault_int && !dl_err;

  out_gate #(.N_OUT(N_OUT)) u_gate (
    .run_en    (run_en),
    .logic_out (logic_out),
    .ext_fail  (ext_fail),
    .off_sel   (off_sel),
    .off_level (off_level),
    .drv_out   (drv_out),
    .off_state (off_state)
  );

  deadline_mon #(.N_OUT(N_OUT), .LIMIT_MS(LIMIT_MS)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .safe_req (mode_q != M_RUN),
    .out_fb   (out_fb),
    .dl_err   (dl_err)
  );

  assign cfg_accept   = (mode_q == M_CONFIG);
  assign mode         = mode_q;
  assign deadline_err = dl_err;

  // R6 R7 R8: outside run mode no output is driven
  assert_safe_outside_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN) |-> (drv_out == '0 && off_state == '0));

  // R9: a deadline error is followed by fatal mode
  assert_err_to_fatal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dl_err |=> (mode_q == M_FATAL));
endmodule

// File: tb/sim_safe_mode_ctrl.sv
module sim_safe_mode_ctrl;
  localparam int N = 4;
  localparam int LIM = 500;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_1ms, startup_ok, fault_int, cfg_req, pwd_ok, cfg_done, upg_req, upg_done;
  logic [N-1:0] logic_out, ext_fail, off_sel, off_level, out_fb;
  logic [N-1:0] drv_out, off_state;
  logic cfg_accept, deadline_err;
  logic [2:0] mode;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  safe_mode_ctrl #(.N_OUT(N), .LIMIT_MS(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .startup_ok(startup_ok),
    .fault_int(fault_int), .cfg_req(cfg_req), .pwd_ok(pwd_ok), .cfg_done(cfg_done),
    .upg_req(upg_req), .upg_done(upg_done), .logic_out(logic_out), .ext_fail(ext_fail),
    .off_sel(off_sel), .off_level(off_level), .out_fb(out_fb), .drv_out(drv_out),
    .off_state(off_state), .cfg_accept(cfg_accept), .mode(mode), .deadline_err(deadline_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tick_1ms = 0; startup_ok = 0; fault_int = 0; cfg_req = 0; pwd_ok = 0;
    cfg_done = 0; upg_req = 0; upg_done = 0; out_fb = '0;
  endtask

  task automatic do_reset();
    idle();
    logic_out = '1; ext_fail = '0; off_sel = '0; off_level = '0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic to_run();
    startup_ok = 1; step(); startup_ok = 0;
  endtask

  task automatic zero_sweep(input string req);
    int bad = 0;
    for (int v = 0; v < 256; v++) begin
      logic_out = v[3:0]; ext_fail = v[7:4]; off_sel = '1; off_level = '1;
      #1;
      if (drv_out != '0 || off_state != '0) bad++;
    end
    chk({req, " outputs held low over sweep"}, bad, 0);
    ext_fail = '0; off_sel = '0; off_level = '0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 drv_out", drv_out, 0);
    chk("R1 off_state", off_state, 0);
    chk("R1 cfg_accept", cfg_accept, 0);
    chk("R1 deadline_err", deadline_err, 0);

    // R2 wait for startup_ok
    step(); step();
    chk("R2 stays startup", mode, 0);
    to_run();
    chk("R2 enters run", mode, 1);

    // R3 R4 exhaustive sweep of the reaction table
    begin
      int bad3 = 0, bad4 = 0;
      for (int v = 0; v < 65536; v++) begin
        logic [N-1:0] lo, ef, os, ol, exp_d, exp_o;
        lo = v[3:0]; ef = v[7:4]; os = v[11:8]; ol = v[15:12];
        logic_out = lo; ext_fail = ef; off_sel = os; off_level = ol;
        #1;
        exp_d = (lo & ~ef) | (ef & os & ol);
        exp_o = ef & os;
        if (drv_out != exp_d) begin
          if (ef == '0) bad3++; else bad4++;
        end
        if (off_state != exp_o) bad4++;
      end
      chk("R3 drive follows logic", bad3, 0);
      chk("R4 external failure reaction", bad4, 0);
    end
    ext_fail = '0; off_sel = '0; off_level = '0; logic_out = '1;

    // R5 unauthorized request ignored
    cfg_req = 1; pwd_ok = 0; step();
    chk("R5 no pwd stays run", mode, 1);
    chk("R5 no pwd cfg_accept", cfg_accept, 0);
    chk("R5 no pwd drive kept", drv_out, 15);
    // R5 authorized with upgrade also requested
    pwd_ok = 1; upg_req = 1; step(); idle();
    chk("R5 enters config", mode, 2);
    chk("R6 cfg_accept", cfg_accept, 1);
    zero_sweep("R6");
    logic_out = '1;
    step();
    chk("R6 stays config", mode, 2);
    cfg_done = 1; step(); cfg_done = 0;
    chk("R6 done to startup", mode, 0);
    chk("R6 cfg_accept off", cfg_accept, 0);
    to_run();

    // R7 upgrade
    upg_req = 1; step(); upg_req = 0;
    chk("R7 enters upgrade", mode, 3);
    chk("R7 cfg_accept", cfg_accept, 0);
    zero_sweep("R7");
    logic_out = '1;
    upg_done = 1; step(); upg_done = 0;
    chk("R7 done to startup", mode, 0);
    to_run();

    // R9 one tick short then feedback clears
    cfg_req = 1; pwd_ok = 1; step(); idle();
    out_fb = 4'b0010; tick_1ms = 1;
    for (int k = 0; k < LIM - 1; k++) step();
    out_fb = '0;
    step(); step();
    chk("R9 short no error", deadline_err, 0);
    chk("R9 short mode", mode, 2);
    tick_1ms = 0;
    cfg_done = 1; step(); cfg_done = 0;
    to_run();

    // R8 fault
    logic_out = '1;
    #1;
    fault_int = 1;
    #1;
    chk("R8 immediate low", drv_out, 0);
    step(); fault_int = 0;
    chk("R8 fatal", mode, 4);
    startup_ok = 1; cfg_req = 1; pwd_ok = 1; upg_done = 1; cfg_done = 1;
    step(); step(); step();
    chk("R8 sticky", mode, 4);
    chk("R8 no cfg in fatal", cfg_accept, 0);
    chk("R8 outputs low", drv_out, 0);
    idle();

    // R1 restart after fatal, then R9 full deadline
    do_reset();
    chk("R1 restart mode", mode, 0);
    chk("R1 restart drive", drv_out, 0);
    to_run();
    cfg_req = 1; pwd_ok = 1; step(); idle();
    out_fb = 4'b1000; tick_1ms = 1;
    for (int k = 0; k < LIM - 1; k++) step();
    chk("R9 before limit", deadline_err, 0);
    step();
    chk("R9 at limit", deadline_err, 1);
    chk("R9 mode not yet fatal", mode, 2);
    step();
    chk("R9 fatal", mode, 4);
    out_fb = '0; tick_1ms = 0;
    step(); step();
    chk("R9 error sticky", deadline_err, 1);

    finish_run();
  end
endmodule